// File: doc/BRIEF.md
# Clock Tuning Control Register File

This block keeps the clock tuning settings for four card-interface channels. Every channel owns two registers, one for the drive clock (type 0) and one for the sample clock (type 1), so eight registers in all. Each register carries three fields:

- a clock-source select bit;
- a two-bit quarter-cycle phase code;
- an eight-bit delay-line tap count.

The decoded fields of all eight registers are driven out at all times, to the phase shifters and delay lines that sit outside this block.

Software reaches the registers through a single address/data port with a registered read. A write carries its own per-bit enable mask in the upper halfword of the data word. Only the enabled bits of the stored lower halfword change. This lets a tuning routine move the phase code or the tap count alone, with no read-modify-write.

Top module: `clk_tune_regs`

## Requirements
- R1: The register for channel c (0..3) and type t (0 drive, 1 sample) sits at byte offset 8*c + 4*t, which is register index 2*c + t.
- R2: A write to a mapped offset updates stored bit n (n in 0..15) only when wdata bit n+16 is 1, and bit n then takes wdata bit n. A write whose upper halfword is zero changes nothing.
- R3: For type-0 registers, clk_sel is bit 11, the tap count is bits [10:3] and the phase code is bits [2:1].
- R4: For type-1 registers, clk_sel is bit 10, the tap count is bits [9:2] and the phase code is bits [1:0]. Phase codes 0..3 stand for 0, 90, 180 and 270 degrees.
- R5: After reset, every stored bit is 0, so every select, phase and tap output is 0.
- R6: One cycle after an address is presented, rdata holds that register's stored lower halfword, with bits [31:16] at zero. The value read is the one stored before any write made in that same cycle.
- R7: Offsets with addr[1:0] != 0, or at 0x20 and above, are unmapped. Writes to them change nothing, and reads of them return 0.
- R8: The outputs follow the stored registers at all times. A write to one register leaves the outputs of every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 6 | Byte offset |
| wdata | input | 32 | [31:16] bit-enable mask, [15:0] data |
| rdata | output | 32 | Read data, registered |
| clk_sel_o | output | 8 | Clock-source select, one bit per register index |
| phase_o | output | 16 | Phase code, 2 bits per register index |
| taps_o | output | 64 | Delay tap count, 8 bits per register index |

## Verification
Every register gets a full-mask write with a distinct value, and every output field is then compared. This separates the type-0 layout from the type-1 layout, and a wrong index would show up as a swapped channel.

Masked writes that touch only the phase bits, or only the tap bits, show whether unmasked bits keep their value. A write with an all-zero mask shows whether anything leaks through without an enable. Writes and reads at misaligned and out-of-range offsets check that unmapped addresses neither alias onto a register nor return data.

// File: rtl/clk_tune_pkg.sv
package clk_tune_pkg;
    localparam int TAP_W = 8;
    localparam int PH_W  = 2;

    typedef struct packed {
        logic             sel;
        logic [PH_W-1:0]  phase;
        logic [TAP_W-1:0] taps;
    } tune_fields_t;
endpackage

// File: rtl/clk_tune_addr_dec.sv
module clk_tune_addr_dec #(
    parameter int NUM_REG = 8,
    parameter int AW      = 6,
    localparam int IW     = $clog2(NUM_REG)
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [AW-3:0] word_idx;

    always_comb begin
        word_idx = addr[AW-1:2];
        idx      = word_idx[IW-1:0];
        hit      = (addr[1:0] == 2'b00) && (int'(word_idx) < NUM_REG);
    end
endmodule

// File: rtl/clk_tune_unpack.sv
module clk_tune_unpack
    import clk_tune_pkg::*;
#(
    parameter int HW   = 16,
    parameter int TYPE = 0
) (
    input  logic [HW-1:0] word,
    output tune_fields_t  fields
);
    // Type 0 sits one bit higher than type 1; align both to the type-1 layout.
    localparam int SH = (TYPE == 0) ? 1 : 0;
    localparam int AL = 1 + TAP_W + PH_W;

    logic [AL-1:0] aligned;

    always_comb begin
        aligned      = AL'(word >> SH);
        fields.sel   = aligned[AL-1];
        fields.taps  = aligned[PH_W+TAP_W-1:PH_W];
        fields.phase = aligned[PH_W-1:0];
    end
endmodule

// File: rtl/clk_tune_regs.sv
module clk_tune_regs
    import clk_tune_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 6,
    parameter int DW     = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    output logic [NUM_CH*2-1:0]         clk_sel_o,
    output logic [NUM_CH*2*PH_W-1:0]    phase_o,
    output logic [NUM_CH*2*TAP_W-1:0]   taps_o
);
    localparam int NUM_REG = NUM_CH * 2;
    localparam int HW      = DW / 2;
    localparam int IW      = $clog2(NUM_REG);

    typedef struct packed {
        logic [NUM_REG-1:0][HW-1:0] regs;
        logic [DW-1:0]              rdata;
    } state_t;

    state_t        st_d, st_q;
    logic          hit;
    logic [IW-1:0] idx;
    logic [HW-1:0] mask;

    clk_tune_addr_dec #(.NUM_REG(NUM_REG), .AW(AW)) u_dec (
        .addr (addr),
        .hit  (hit),
        .idx  (idx)
    );

    always_comb begin
        st_d     = st_q;
        mask     = wdata[DW-1:HW];
        st_d.rdata = hit ? {{(DW-HW){1'b0}}, st_q.regs[idx]} : '0;
        if (wr_en && hit) begin
            st_d.regs[idx] = (st_q.regs[idx] & ~mask) | (wdata[HW-1:0] & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        tune_fields_t f;
        clk_tune_unpack #(.HW(HW), .TYPE(r % 2)) u_unpack (
            .word   (st_q.regs[r]),
            .fields (f)
        );
        assign clk_sel_o[r]                  = f.sel;
        assign phase_o[r*PH_W +: PH_W]       = f.phase;
        assign taps_o[r*TAP_W +: TAP_W]      = f.taps;
    end
endmodule

// File: rtl/clk_tune_regs_chk.sv
module clk_tune_regs_chk
    import clk_tune_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int AW     = 6,
    parameter int DW     = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input logic [AW-1:0]               addr,
    input logic [DW-1:0]               wdata,
    input logic [DW-1:0]               rdata,
    input logic [NUM_CH*2-1:0]         clk_sel_o,
    input logic [NUM_CH*2*PH_W-1:0]    phase_o,
    input logic [NUM_CH*2*TAP_W-1:0]   taps_o
);
    localparam int HW = DW / 2;

    logic mapped;
    assign mapped = (addr[1:0] == 2'b00) && (int'(addr[AW-1:2]) < NUM_CH * 2);

    // R2
    zero_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[DW-1:HW] == '0) |=>
            ($stable(clk_sel_o) && $stable(phase_o) && $stable(taps_o)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(clk_sel_o) && $stable(phase_o) && $stable(taps_o)));

    // R7
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mapped) |=>
            ($stable(clk_sel_o) && $stable(phase_o) && $stable(taps_o)));

    // R7
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |=> (rdata == '0));

    // R5
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (clk_sel_o == '0 && phase_o == '0 && taps_o == '0);
        end
    end
endmodule

bind clk_tune_regs clk_tune_regs_chk #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/clk_tune_regs_tb.sv
module clk_tune_regs_tb;
    localparam int NREG = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  clk_sel_o;
    logic [15:0] phase_o;
    logic [63:0] taps_o;

    int errors = 0;
    int checks = 0;
    logic [15:0] mdl [NREG];
    logic [31:0] expq [$];
    string       tagq [$];
    logic        tb_rd = 1'b0;
    logic        rd_seen = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    clk_tune_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .clk_sel_o(clk_sel_o), .phase_o(phase_o), .taps_o(taps_o)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_mapped(logic [5:0] a);
        return (a[1:0] == 2'b00) && (a < 6'h20);
    endfunction

    // Compare every register's outputs with the bench model (R3, R4, R8)
    task automatic check_outs(string req);
        for (int r = 0; r < NREG; r++) begin
            logic       es;
            logic [1:0] ep;
            logic [7:0] et;
            if (r % 2 == 0) begin es = mdl[r][11]; et = mdl[r][10:3]; ep = mdl[r][2:1]; end
            else            begin es = mdl[r][10]; et = mdl[r][9:2];  ep = mdl[r][1:0]; end
            check(req, {63'b0, clk_sel_o[r]}, {63'b0, es});
            check(req, {62'b0, phase_o[2*r +: 2]}, {62'b0, ep});
            check(req, {56'b0, taps_o[8*r +: 8]}, {56'b0, et});
        end
    endtask

    task automatic do_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (is_mapped(a))
            mdl[a[4:2]] = (mdl[a[4:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
    endtask

    // Driver: pushes expected read data; monitor compares one cycle later
    task automatic do_read(logic [5:0] a, string req);
        @(negedge clk);
        addr = a; tb_rd = 1'b1;
        expq.push_back(is_mapped(a) ? {16'h0, mdl[a[4:2]]} : 32'h0);
        tagq.push_back(req);
        @(negedge clk);
        tb_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= tb_rd;

    always @(negedge clk) begin
        if (rd_seen && expq.size() > 0) begin
            logic [31:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, {32'b0, rdata}, {32'b0, e});
        end
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NREG; r++) mdl[r] = '0;
        repeat (3) @(negedge clk);
        // R5: reset state
        check_outs("R5");
        rst_n = 1'b1;
        do_read(6'h00, "R5");
        do_read(6'h1C, "R5");

        // R3: type-0 register, channel 1 (offset 0x08)
        do_write(6'h08, 32'hFFFF_0A5C);
        check_outs("R3");
        // R4: type-1 register, channel 2 (offset 0x14)
        do_write(6'h14, 32'hFFFF_07F7);
        check_outs("R4");

        // R1: distinct value in every register, then read back all
        for (int r = 0; r < NREG; r++) begin
            logic [5:0] off;
            off = 6'(r * 4);
            do_write(off, {16'hFFFF, 16'(16'h1357 * (r + 1))});
        end
        check_outs("R1");
        for (int r = 0; r < NREG; r++) begin
            logic [5:0] off;
            off = 6'(r * 4);
            do_read(off, "R1");
        end

        // R2: phase-only update on type-0 and tap-only update on type-1
        do_write(6'h08, 32'h0006_0004);
        check_outs("R2");
        do_write(6'h0C, 32'h03FC_0154);
        check_outs("R2");
        do_write(6'h18, 32'h0000_FFFF);
        check_outs("R2");
        do_read(6'h18, "R2");

        // R7: unmapped writes and reads
        do_write(6'h20, 32'hFFFF_FFFF);
        do_write(6'h09, 32'hFFFF_0000);
        do_write(6'h3C, 32'hFFFF_1234);
        check_outs("R7");
        do_read(6'h20, "R7");
        do_read(6'h0A, "R7");
        do_read(6'h3C, "R7");

        // R6: read in the write cycle returns the old value
        @(negedge clk);
        wr_en = 1'b1; addr = 6'h04; wdata = 32'hFFFF_0ABC; tb_rd = 1'b1;
        expq.push_back({16'h0, mdl[1]}); tagq.push_back("R6");
        @(negedge clk);
        wr_en = 1'b0; tb_rd = 1'b0;
        mdl[1] = 16'h0ABC;
        do_read(6'h04, "R6");

        // R8: single-register update leaves others unchanged
        do_write(6'h10, 32'h0800_0800);
        check_outs("R8");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule